// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether an incoming frame should be taken in, based on the 48-bit destination address and the frame length. A receive path presents the address, the length and the current filter mode bits together with a one-cycle `start` strobe. One clock later the block raises `done` for a single cycle, and `accept` carries the verdict in that same cycle.

The block holds the station address and a 64-bit multicast hash table. Each one is loaded through its own strobe. Address byte 0, the first byte on the wire, sits in `dest_addr[7:0]` and byte 5 sits in `dest_addr[47:40]`. The station address uses the same layout.

The verdict is built in a fixed order of precedence:
1. Receive enable and the length window act as a hard gate.
2. Promiscuous mode accepts everything.
3. The all-ones broadcast address is handled next.
4. Multicast frames may then be passed wholesale.
5. Each remaining frame goes through either an exact compare against the station address (optionally inverted) or a lookup in the hash table indexed by a CRC-32. Unicast and multicast frames select between the two methods independently.
6. A receive-all bit overrides any rejection made by the filter itself.

Top module: `rx_addr_filter`

## Requirements
- R1: When `rx_enable` is 0, `accept` is 0. When `frame_len` is below 14 or is 2048 or more, `accept` is 0. This gate holds even with promiscuous mode or receive-all set.
- R2: With `promisc` set, every address inside the length gate is accepted.
- R3: When not promiscuous, the all-ones address is accepted if `bcast_block` is 0 and rejected by the filter if `bcast_block` is 1.
- R4: An address is multicast when `dest_addr[0]` (bit 0 of byte 0) is 1. A non-broadcast multicast address is accepted when `mcast_pass_all` is set.
- R5: Unicast addresses use an exact compare with the station address when `ucast_hash_only` is 0. Multicast addresses use the exact compare when `mcast_use_hash` is 0. Otherwise the hash lookup decides.
- R6: `inverse` inverts the result of the exact compare. It has no effect on the hash lookup.
- R7: The hash index is CRC bits 31:26. The CRC uses polynomial 0x04C11DB7 and starts from an all-ones preset. It is fed `dest_addr[0]` first through `dest_addr[47]` last, with a shift toward the MSB and no final inversion. The index selects bit `index` of the 64-bit table: index 32..63 falls in the high word `hash_in[63:32]` and index 0..31 in the low word.
- R8: With `receive_all` set, a frame rejected by the filter (R3 to R7) is accepted anyway.
- R9: `done` is 1 in exactly the cycle after a `start`, and is 0 otherwise. `accept` is 0 whenever `done` is 0.
- R10: After reset, the station address and hash table are zero. A load takes effect only for a `start` in a later cycle; a `start` in the same cycle as a load sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the presented frame this cycle |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | LEN_W | Frame length in bytes |
| rx_enable | input | 1 | Receive enabled |
| promisc | input | 1 | Accept all addresses |
| bcast_block | input | 1 | Reject broadcast |
| mcast_pass_all | input | 1 | Accept all multicast |
| ucast_hash_only | input | 1 | Unicast uses hash lookup |
| mcast_use_hash | input | 1 | Multicast uses hash lookup |
| inverse | input | 1 | Invert the exact compare |
| receive_all | input | 1 | Accept frames the filter rejects |
| sta_load | input | 1 | Load station address |
| sta_addr_in | input | 48 | New station address |
| hash_load | input | 1 | Load hash table |
| hash_in | input | 64 | New hash table |
| done | output | 1 | Verdict valid pulse |
| accept | output | 1 | Frame accepted |

## Verification
The bench probes both edges of the length window: 13 and 2048 must reject, 14 and 2047 must accept. An off-by-one comparison would flip one of these four results.

For the hash path, the bench computes the index itself and loads a table holding either only that bit or every bit except that one. A wrong bit order, preset or word select would accept in the wrong one of the two cases.

Further cases separate the exact compare from the hash lookup:
- Inverse mode is applied on a hash-mode frame, where it must change nothing.
- A station-matching address is sent with hash-only mode set and an empty table, where it must be rejected.

Receive-all is shown to rescue a blocked broadcast while still losing to a disabled receiver. Finally, a station load issued in the same cycle as `start` must not affect that decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int ADDR_W  = 48;
   localparam int TABLE_W = 64;
   localparam int IDX_W   = 6;
   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

   typedef struct packed {
      logic promisc;
      logic bcast_block;
      logic mcast_pass_all;
      logic ucast_hash_only;
      logic mcast_use_hash;
      logic inverse;
      logic receive_all;
   } filt_mode_t;
endpackage

// File: rtl/rxf_crc_index.sv
module rxf_crc_index
   import rxf_pkg::*;
#(
   parameter int DATA_W = ADDR_W,
   parameter int OUT_W  = IDX_W
) (
   input  logic [DATA_W-1:0] data,
   output logic [OUT_W-1:0]  index
);
   if (OUT_W < 1 || OUT_W > 32) begin : g_bad_w
      $error("rxf_crc_index: OUT_W out of range");
   end

   // one shift stage per input bit, LSB of data first
   logic [31:0] stage [0:DATA_W];
   assign stage[0] = 32'hFFFF_FFFF;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb = stage[i][31] ^ data[i];
      assign stage[i+1] = {stage[i][30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
   end

   assign index = stage[DATA_W][31 -: OUT_W];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int TBL_W = TABLE_W,
   parameter int IW    = IDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] station,
   input  logic [TBL_W-1:0]  table_bits,
   input  logic [IW-1:0]     index,
   input  filt_mode_t        mode,
   output logic              pass
);
   if (TBL_W != (1 << IW)) begin : g_bad_tbl
      $error("rxf_decide: table width must be 2**index width");
   end

   logic is_bcast, is_mcast, exact_hit, use_exact, hash_hit, verdict;

   assign is_bcast  = &addr;
   assign is_mcast  = addr[0];
   assign exact_hit = (addr == station);
   assign use_exact = is_mcast ? !mode.mcast_use_hash : !mode.ucast_hash_only;
   assign hash_hit  = table_bits[index];

   always_comb begin
      if (mode.promisc)                          verdict = 1'b1;
      else if (is_bcast)                         verdict = !mode.bcast_block;
      else if (is_mcast && mode.mcast_pass_all)  verdict = 1'b1;
      else if (use_exact)                        verdict = exact_hit ^ mode.inverse;
      else                                       verdict = hash_hit;
   end

   assign pass = verdict | mode.receive_all;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 14,
   parameter int MAX_LEN = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [47:0]       dest_addr,
   input  logic [LEN_W-1:0]  frame_len,
   input  logic              rx_enable,
   input  logic              promisc,
   input  logic              bcast_block,
   input  logic              mcast_pass_all,
   input  logic              ucast_hash_only,
   input  logic              mcast_use_hash,
   input  logic              inverse,
   input  logic              receive_all,
   input  logic              sta_load,
   input  logic [47:0]       sta_addr_in,
   input  logic              hash_load,
   input  logic [63:0]       hash_in,
   output logic              done,
   output logic              accept
);
   localparam logic [LEN_W:0] LEN_LO = (LEN_W+1)'(MIN_LEN);
   localparam logic [LEN_W:0] LEN_HI = (LEN_W+1)'(MAX_LEN);

   if (MIN_LEN < 1 || MIN_LEN >= MAX_LEN) begin : g_bad_len
      $error("rx_addr_filter: MIN_LEN must be below MAX_LEN");
   end
   if (MAX_LEN > (1 << LEN_W)) begin : g_bad_lenw
      $error("rx_addr_filter: LEN_W too narrow for MAX_LEN");
   end

   logic [ADDR_W-1:0]  sta_q;
   logic [TABLE_W-1:0] hash_q;
   logic [IDX_W-1:0]   hidx;
   logic               filt_pass, len_ok;
   filt_mode_t         mode;

   assign mode = '{promisc: promisc, bcast_block: bcast_block,
                   mcast_pass_all: mcast_pass_all, ucast_hash_only: ucast_hash_only,
                   mcast_use_hash: mcast_use_hash, inverse: inverse,
                   receive_all: receive_all};

   assign len_ok = ({1'b0, frame_len} >= LEN_LO) && ({1'b0, frame_len} < LEN_HI);

   rxf_crc_index #(.DATA_W(ADDR_W), .OUT_W(IDX_W)) u_crc (
      .data  (dest_addr),
      .index (hidx)
   );

   rxf_decide #(.TBL_W(TABLE_W), .IW(IDX_W)) u_dec (
      .addr       (dest_addr),
      .station    (sta_q),
      .table_bits (hash_q),
      .index      (hidx),
      .mode       (mode),
      .pass       (filt_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_q  <= '0;
         hash_q <= '0;
      end else begin
         if (sta_load)  sta_q  <= sta_addr_in;
         if (hash_load) hash_q <= hash_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         accept <= 1'b0;
      end else begin
         done   <= start;
         accept <= start && rx_enable && len_ok && filt_pass;
      end
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done) else $error("done missing");                        // R9
   AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done) else $error("stray done");                        // R9
   AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !accept) else $error("accept without done");              // R9
   AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !rx_enable) |=> !accept) else $error("accept while off");  // R1
   AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rx_enable && promisc && frame_len >= LEN_W'(MIN_LEN)
       && frame_len < LEN_W'(MAX_LEN - 1) + LEN_W'(1) && frame_len <= LEN_W'(MAX_LEN - 1))
      |=> accept) else $error("promisc reject");                          // R2
   AST_RXALL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rx_enable && receive_all && frame_len >= LEN_W'(MIN_LEN)
       && frame_len <= LEN_W'(MAX_LEN - 1))
      |=> accept) else $error("receive-all reject");                      // R8
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, start;
   logic [47:0] dest_addr;
   logic [15:0] frame_len;
   logic        rx_enable, promisc, bcast_block, mcast_pass_all;
   logic        ucast_hash_only, mcast_use_hash, inverse, receive_all;
   logic        sta_load, hash_load;
   logic [47:0] sta_addr_in;
   logic [63:0] hash_in;
   logic        done, accept;

   int total = 0;
   int bad   = 0;

   localparam logic [47:0] STA  = 48'h0605_0403_0210;
   localparam logic [47:0] UNI2 = 48'h5544_3322_1100;
   localparam logic [47:0] MC1  = 48'h0000_5E00_0001;
   localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

   rx_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dest_addr(dest_addr),
      .frame_len(frame_len), .rx_enable(rx_enable), .promisc(promisc),
      .bcast_block(bcast_block), .mcast_pass_all(mcast_pass_all),
      .ucast_hash_only(ucast_hash_only), .mcast_use_hash(mcast_use_hash),
      .inverse(inverse), .receive_all(receive_all), .sta_load(sta_load),
      .sta_addr_in(sta_addr_in), .hash_load(hash_load), .hash_in(hash_in),
      .done(done), .accept(accept)
   );

   function automatic logic [5:0] ref_index(input logic [47:0] a);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         logic [7:0] by;
         by = a[b*8 +: 8];
         for (int k = 0; k < 8; k++) begin
            logic top;
            top = c[31];
            c = c << 1;
            if (top != by[k]) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c[31:26];
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic clear_mode();
      rx_enable = 1; promisc = 0; bcast_block = 0; mcast_pass_all = 0;
      ucast_hash_only = 0; mcast_use_hash = 0; inverse = 0; receive_all = 0;
   endtask

   task automatic load_sta(input logic [47:0] a);
      @(negedge clk); sta_load = 1; sta_addr_in = a;
      @(negedge clk); sta_load = 0;
   endtask

   task automatic load_hash(input logic [63:0] h);
      @(negedge clk); hash_load = 1; hash_in = h;
      @(negedge clk); hash_load = 0;
   endtask

   task automatic eval(input string req, input logic [47:0] a, input int len,
                       input logic exp);
      @(negedge clk);
      dest_addr = a; frame_len = 16'(len); start = 1;
      @(negedge clk);
      start = 0;
      check(req, done, 1'b1);
      check(req, accept, exp);
   endtask

   task automatic t_reset();
      check("R9", done, 1'b0);
      check("R9", accept, 1'b0);
      clear_mode();
      eval("R10", 48'h0, 64, 1'b1);   // station zero after reset: exact hit
      ucast_hash_only = 1;
      eval("R10", UNI2, 64, 1'b0);    // empty table
   endtask

   task automatic t_gate();
      clear_mode(); promisc = 1;
      eval("R1", UNI2, 13, 1'b0);
      eval("R1", UNI2, 14, 1'b1);
      eval("R1", UNI2, 2047, 1'b1);
      eval("R1", UNI2, 2048, 1'b0);
      rx_enable = 0; receive_all = 1;
      eval("R1", UNI2, 100, 1'b0);
   endtask

   task automatic t_promisc();
      clear_mode();
      eval("R2", UNI2, 64, 1'b0);
      promisc = 1; bcast_block = 1;
      eval("R2", UNI2, 64, 1'b1);
      eval("R2", BC, 64, 1'b1);
   endtask

   task automatic t_bcast();
      clear_mode();
      eval("R3", BC, 64, 1'b1);
      bcast_block = 1;
      eval("R3", BC, 64, 1'b0);
      receive_all = 1;
      eval("R8", BC, 64, 1'b1);
   endtask

   task automatic t_mcast();
      clear_mode();
      eval("R4", MC1, 64, 1'b0);
      mcast_pass_all = 1;
      eval("R4", MC1, 64, 1'b1);
      eval("R4", UNI2, 64, 1'b0);     // unicast not passed
   endtask

   task automatic t_exact();
      clear_mode();
      eval("R5", STA, 64, 1'b1);
      eval("R5", UNI2, 64, 1'b0);
      inverse = 1;
      eval("R6", STA, 64, 1'b0);
      eval("R6", UNI2, 64, 1'b1);
      inverse = 0; ucast_hash_only = 1;
      load_hash(64'h0);
      eval("R5", STA, 64, 1'b0);
      receive_all = 1;
      eval("R8", STA, 64, 1'b1);
   endtask

   task automatic t_hash();
      logic [5:0] iu, im;
      iu = ref_index(UNI2);
      im = ref_index(MC1);
      clear_mode(); ucast_hash_only = 1; mcast_use_hash = 1;
      load_hash(64'h1 << iu);
      eval("R7", UNI2, 64, 1'b1);
      inverse = 1;
      eval("R6", UNI2, 64, 1'b1);
      inverse = 0;
      load_hash(~(64'h1 << iu));
      eval("R7", UNI2, 64, 1'b0);
      load_hash(64'h1 << im);
      eval("R7", MC1, 64, 1'b1);
      load_hash(~(64'h1 << im));
      eval("R7", MC1, 64, 1'b0);
   endtask

   task automatic t_timing();
      clear_mode(); promisc = 1;
      eval("R9", UNI2, 64, 1'b1);
      @(negedge clk);
      check("R9", done, 1'b0);
      check("R9", accept, 1'b0);
   endtask

   task automatic t_load();
      clear_mode();
      load_sta(STA);
      @(negedge clk);
      sta_load = 1; sta_addr_in = UNI2;
      dest_addr = UNI2; frame_len = 64; start = 1;
      @(negedge clk);
      sta_load = 0; start = 0;
      check("R10", accept, 1'b0);     // old station used
      eval("R10", UNI2, 64, 1'b1);    // new station now active
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; start = 0; dest_addr = '0; frame_len = '0;
      sta_load = 0; hash_load = 0; sta_addr_in = '0; hash_in = '0;
      clear_mode();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      load_sta(STA);
      t_gate();
      t_promisc();
      t_bcast();
      t_mcast();
      t_exact();
      t_hash();
      t_timing();
      t_load();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule